// File: doc/BRIEF.md
# Three-Row Linear CCD Drive Timing Generator

This block derives all drive waveforms for a three-colour linear CCD sensor from a single fast system clock. For each line it first runs a transfer window, in which the shift clocks sit at static levels and the three row transfer gates pulse together, and then a burst of pixel periods. In each pixel period it produces the two complementary shift clock phases, a separate last-stage clock, a reset gate pulse and, in per-pixel clamping, a clamp pulse. Every width, gap and period is a count of system-clock cycles supplied on input pins. All of these inputs and the clamp mode are captured when a line starts.

Alongside the drive waveforms the block publishes, for a downstream converter capture stage, the index of the current pixel period, a one-hot zone tag (leading or trailing dummy, optical black, valid) and a one-cycle strobe at the sample point of each valid pixel. These are plain timing outputs that run freely once a line starts. There is no valid/ready handshake and no back-pressure: a consumer that cannot take a strobe loses it, and the sensor cannot be paused in the middle of a line. Pixel zone sizes are parameters and default to a 5469-period line with 5400 valid pixels.

Top module: `ccd_line_timer`

## Requirements
- R1: While the synchronous active-high `rst` is high, and on the first cycle after it, the outputs are: `busy`=0, `tg_rows`=0, `rs_pulse`=0, `clamp`=0, `phi1`=1, `phi2`=0, `phi1_last`=1, `pix_index`=0, all zone flags 0 and `valid_stb`=0.
- R2: A `line_start` pulse while idle begins a line. `busy` then stays high for exactly setup + width + hold + TOTAL × period cycles, where TOTAL is the number of pixel periods per line. A `line_start` pulse while `busy` is high is ignored.
- R3: All `tg_rows` bits (bit 0 blue, bit 1 green, bit 2 red) rise together once per line and stay high for exactly `tg_width` cycles. They are preceded by `tg_setup` cycles and followed by `tg_hold` cycles, and throughout that window the shift clocks are static at `phi1`=1, `phi2`=0, `phi1_last`=1.
- R4: In bit clamp mode (`line_mode_sel`=0), `rs_pulse` and `clamp` are both high on every cycle of the setup, transfer and hold window.
- R5: In line clamp mode (`line_mode_sel`=1), `clamp` equals the inverse of the transfer gate pulse and `rs_pulse` stays low across the whole setup, transfer and hold window.
- R6: In bit clamp mode, on cycle c of each pixel period `rs_pulse` is high for c < `rst_width` and `clamp` is high for `rst_width`+`rst_clamp_gap` ≤ c < `rst_width`+`rst_clamp_gap`+`clamp_width`. A gap of 0 puts the clamp pulse directly after the reset pulse.
- R7: In line clamp mode, each pixel period holds exactly one reset pulse of `rst_width` cycles and `clamp` stays high for the whole burst.
- R8: On cycle c of a pixel period of P cycles, `phi1` is high for c < P/2 (rounded down) and `phi2` is its complement. `phi1_last` rises with `phi1` and falls one cycle before it, so it is low on the cycle in which `phi2` rises.
- R9: A line contains TOTAL pixel periods. `pix_index` counts 1 to TOTAL, is 0 outside the burst, and steps in the same cycle that `rs_pulse` rises.
- R10: The zone flags are one-hot during the burst and 0 outside it, decoded from `pix_index`. The leading `N_FRONT` periods are dummy, the next `N_OB` are optical black, the next `N_GAP` are dummy, the next `N_VALID` are valid, and the final `N_TAIL` are dummy.
- R11: `valid_stb` is high for one cycle, on the last cycle of each valid pixel period, and nowhere else. It therefore pulses `N_VALID` times per line.
- R12: Clamp mode, pixel period and all widths are captured at line start. Changing them during a line has no effect until the next line.
- R13: The pixel period is programmable. Both even and odd periods of 4 cycles or more give the waveforms of R6 to R8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_start | input | 1 | Start-of-line strobe, honoured only when idle |
| line_mode_sel | input | 1 | 0 = bit clamp, 1 = line clamp |
| pix_period | input | TW | Pixel period in cycles (≥ 4) |
| rst_width | input | TW | Reset pulse width in cycles (≥ 1) |
| rst_clamp_gap | input | TW | Cycles from reset fall to clamp rise |
| clamp_width | input | TW | Clamp pulse width in cycles, bit clamp mode |
| tg_setup | input | TW | Static cycles before the transfer gate (≥ 1) |
| tg_width | input | TW | Transfer gate width in cycles (≥ 1) |
| tg_hold | input | TW | Static cycles after the transfer gate (≥ 1) |
| phi1 | output | 1 | Shift clock phase 1 |
| phi2 | output | 1 | Shift clock phase 2 |
| phi1_last | output | 1 | Last-stage shift clock |
| rs_pulse | output | 1 | Reset gate pulse |
| clamp | output | 1 | Clamp pulse or level |
| tg_rows | output | N_ROWS | Transfer gates: bit 0 blue, bit 1 green, bit 2 red |
| busy | output | 1 | High while a line is in progress |
| pix_index | output | PIX_W | Current pixel period, 0 outside the burst |
| zone_dummy | output | 1 | Current period is a dummy element |
| zone_ob | output | 1 | Current period is optical black |
| zone_valid | output | 1 | Current period is a valid pixel |
| valid_stb | output | 1 | Sample strobe of a valid pixel |

## Verification
Two things can fall in the same cycle. The first is the step of the pixel index and zone tag together with the rise of the reset pulse, which the bench checks on every pixel boundary against a cycle-in-period model. The second is a new start strobe together with a change of every timing input while a burst is running. To provoke the second, the bench changes the clamp mode and the period and pulses `line_start` in the middle of a line. It judges the result by comparing the busy length and every pixel waveform with the values captured at the start of that line, and by confirming that no second line follows.

// File: rtl/ccd_timer_pkg.sv
package ccd_timer_pkg;
  // Width of every programmable cycle count.
  parameter int unsigned TW = 16;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SETUP,
    PH_XFER,
    PH_HOLD,
    PH_PIX
  } phase_t;

  typedef enum logic [1:0] {
    ZN_NONE,
    ZN_DUMMY,
    ZN_OB,
    ZN_VALID
  } zone_t;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timer_pkg::*;
#(
  parameter int unsigned TOTAL = 5469,
  parameter int unsigned PIX_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             line_start,
  input  logic             mode_in,
  input  logic [TW-1:0]    period_in,
  input  logic [TW-1:0]    rst_w_in,
  input  logic [TW-1:0]    gap_in,
  input  logic [TW-1:0]    clp_w_in,
  input  logic [TW-1:0]    setup_in,
  input  logic [TW-1:0]    xfer_in,
  input  logic [TW-1:0]    hold_in,
  output phase_t           phase,
  output logic [PIX_W-1:0] pix_num,
  output logic [TW-1:0]    pix_cyc,
  output logic             mode_q,
  output logic [TW-1:0]    period_q,
  output logic [TW-1:0]    rst_w_q,
  output logic [TW-1:0]    gap_q,
  output logic [TW-1:0]    clp_w_q
);
  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(TOTAL);

  logic [TW-1:0] seg;
  logic [TW-1:0] setup_q, xfer_q, hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      seg      <= '0;
      pix_num  <= '0;
      pix_cyc  <= '0;
      mode_q   <= 1'b0;
      period_q <= '0;
      rst_w_q  <= '0;
      gap_q    <= '0;
      clp_w_q  <= '0;
      setup_q  <= '0;
      xfer_q   <= '0;
      hold_q   <= '0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (line_start) begin
            phase    <= PH_SETUP;
            seg      <= '0;
            mode_q   <= mode_in;
            period_q <= period_in;
            rst_w_q  <= rst_w_in;
            gap_q    <= gap_in;
            clp_w_q  <= clp_w_in;
            setup_q  <= setup_in;
            xfer_q   <= xfer_in;
            hold_q   <= hold_in;
          end
        end
        PH_SETUP: begin
          if (seg == setup_q - TW'(1)) begin
            phase <= PH_XFER;
            seg   <= '0;
          end else begin
            seg <= seg + TW'(1);
          end
        end
        PH_XFER: begin
          if (seg == xfer_q - TW'(1)) begin
            phase <= PH_HOLD;
            seg   <= '0;
          end else begin
            seg <= seg + TW'(1);
          end
        end
        PH_HOLD: begin
          if (seg == hold_q - TW'(1)) begin
            phase   <= PH_PIX;
            seg     <= '0;
            pix_num <= PIX_W'(1);
            pix_cyc <= '0;
          end else begin
            seg <= seg + TW'(1);
          end
        end
        PH_PIX: begin
          if (pix_cyc == period_q - TW'(1)) begin
            pix_cyc <= '0;
            if (pix_num == LAST_PIX) begin
              phase   <= PH_IDLE;
              pix_num <= '0;
            end else begin
              pix_num <= pix_num + PIX_W'(1);
            end
          end else begin
            pix_cyc <= pix_cyc + TW'(1);
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ccd_pixel_wave.sv
module ccd_pixel_wave
  import ccd_timer_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  phase_t        phase,
  input  logic [TW-1:0] pix_cyc,
  input  logic          mode_line,
  input  logic [TW-1:0] period,
  input  logic [TW-1:0] rst_w,
  input  logic [TW-1:0] gap,
  input  logic [TW-1:0] clp_w,
  output logic          phi1,
  output logic          phi2,
  output logic          phi1_last,
  output logic          rs_pulse,
  output logic          clamp,
  output logic          xfer
);
  logic [TW-1:0] half, clp_beg, clp_end;
  logic n_phi1, n_phi2, n_last, n_rs, n_clp, n_xfer;

  assign half    = period >> 1;
  assign clp_beg = rst_w + gap;
  assign clp_end = clp_beg + clp_w;

  always_comb begin
    n_phi1 = 1'b1;
    n_phi2 = 1'b0;
    n_last = 1'b1;
    n_rs   = 1'b0;
    n_clp  = 1'b0;
    n_xfer = 1'b0;
    unique case (phase)
      PH_IDLE: ;
      PH_SETUP, PH_HOLD: begin
        n_rs  = !mode_line;
        n_clp = 1'b1;
      end
      PH_XFER: begin
        n_rs   = !mode_line;
        n_clp  = !mode_line;
        n_xfer = 1'b1;
      end
      PH_PIX: begin
        n_phi1 = pix_cyc < half;
        n_phi2 = !n_phi1;
        n_last = (pix_cyc + TW'(1)) < half;
        n_rs   = pix_cyc < rst_w;
        n_clp  = mode_line || ((pix_cyc >= clp_beg) && (pix_cyc < clp_end));
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phi1      <= 1'b1;
      phi2      <= 1'b0;
      phi1_last <= 1'b1;
      rs_pulse  <= 1'b0;
      clamp     <= 1'b0;
      xfer      <= 1'b0;
    end else begin
      phi1      <= n_phi1;
      phi2      <= n_phi2;
      phi1_last <= n_last;
      rs_pulse  <= n_rs;
      clamp     <= n_clp;
      xfer      <= n_xfer;
    end
  end
endmodule

// File: rtl/ccd_zone_tag.sv
module ccd_zone_tag
  import ccd_timer_pkg::*;
#(
  parameter int unsigned N_FRONT = 13,
  parameter int unsigned N_OB    = 49,
  parameter int unsigned N_GAP   = 3,
  parameter int unsigned N_VALID = 5400,
  parameter int unsigned PIX_W   = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  phase_t           phase,
  input  logic [PIX_W-1:0] pix_num,
  input  logic [TW-1:0]    pix_cyc,
  input  logic [TW-1:0]    period,
  output logic [PIX_W-1:0] pix_index,
  output logic             zone_dummy,
  output logic             zone_ob,
  output logic             zone_valid,
  output logic             valid_stb
);
  localparam int unsigned END_FRONT = N_FRONT;
  localparam int unsigned END_OB    = END_FRONT + N_OB;
  localparam int unsigned END_GAP   = END_OB + N_GAP;
  localparam int unsigned END_VALID = END_GAP + N_VALID;

  zone_t zn;
  logic  in_burst;

  assign in_burst = (phase == PH_PIX);

  always_comb begin
    zn = ZN_NONE;
    if (in_burst) begin
      if (pix_num <= PIX_W'(END_FRONT))      zn = ZN_DUMMY;
      else if (pix_num <= PIX_W'(END_OB))    zn = ZN_OB;
      else if (pix_num <= PIX_W'(END_GAP))   zn = ZN_DUMMY;
      else if (pix_num <= PIX_W'(END_VALID)) zn = ZN_VALID;
      else                                   zn = ZN_DUMMY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_index  <= '0;
      zone_dummy <= 1'b0;
      zone_ob    <= 1'b0;
      zone_valid <= 1'b0;
      valid_stb  <= 1'b0;
    end else begin
      pix_index  <= in_burst ? pix_num : '0;
      zone_dummy <= (zn == ZN_DUMMY);
      zone_ob    <= (zn == ZN_OB);
      zone_valid <= (zn == ZN_VALID);
      valid_stb  <= (zn == ZN_VALID) && (pix_cyc == period - TW'(1));
    end
  end
endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timer_pkg::*;
#(
  parameter int unsigned N_FRONT = 13,
  parameter int unsigned N_OB    = 49,
  parameter int unsigned N_GAP   = 3,
  parameter int unsigned N_VALID = 5400,
  parameter int unsigned N_TAIL  = 4,
  parameter int unsigned N_ROWS  = 3,
  parameter int unsigned PIX_W   = $clog2(N_FRONT + N_OB + N_GAP + N_VALID + N_TAIL + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              line_start,
  input  logic              line_mode_sel,
  input  logic [TW-1:0]     pix_period,
  input  logic [TW-1:0]     rst_width,
  input  logic [TW-1:0]     rst_clamp_gap,
  input  logic [TW-1:0]     clamp_width,
  input  logic [TW-1:0]     tg_setup,
  input  logic [TW-1:0]     tg_width,
  input  logic [TW-1:0]     tg_hold,
  output logic              phi1,
  output logic              phi2,
  output logic              phi1_last,
  output logic              rs_pulse,
  output logic              clamp,
  output logic [N_ROWS-1:0] tg_rows,
  output logic              busy,
  output logic [PIX_W-1:0]  pix_index,
  output logic              zone_dummy,
  output logic              zone_ob,
  output logic              zone_valid,
  output logic              valid_stb
);
  localparam int unsigned TOTAL = N_FRONT + N_OB + N_GAP + N_VALID + N_TAIL;

  phase_t           phase;
  logic [PIX_W-1:0] pix_num;
  logic [TW-1:0]    pix_cyc;
  logic             mode_q;
  logic [TW-1:0]    period_q, rst_w_q, gap_q, clp_w_q;
  logic             xfer;

  ccd_line_seq #(.TOTAL(TOTAL), .PIX_W(PIX_W)) u_seq (
    .clk(clk), .rst(rst), .line_start(line_start),
    .mode_in(line_mode_sel), .period_in(pix_period), .rst_w_in(rst_width),
    .gap_in(rst_clamp_gap), .clp_w_in(clamp_width), .setup_in(tg_setup),
    .xfer_in(tg_width), .hold_in(tg_hold),
    .phase(phase), .pix_num(pix_num), .pix_cyc(pix_cyc),
    .mode_q(mode_q), .period_q(period_q), .rst_w_q(rst_w_q),
    .gap_q(gap_q), .clp_w_q(clp_w_q)
  );

  ccd_pixel_wave u_wave (
    .clk(clk), .rst(rst), .phase(phase), .pix_cyc(pix_cyc),
    .mode_line(mode_q), .period(period_q), .rst_w(rst_w_q),
    .gap(gap_q), .clp_w(clp_w_q),
    .phi1(phi1), .phi2(phi2), .phi1_last(phi1_last),
    .rs_pulse(rs_pulse), .clamp(clamp), .xfer(xfer)
  );

  ccd_zone_tag #(
    .N_FRONT(N_FRONT), .N_OB(N_OB), .N_GAP(N_GAP),
    .N_VALID(N_VALID), .PIX_W(PIX_W)
  ) u_zone (
    .clk(clk), .rst(rst), .phase(phase), .pix_num(pix_num),
    .pix_cyc(pix_cyc), .period(period_q),
    .pix_index(pix_index), .zone_dummy(zone_dummy), .zone_ob(zone_ob),
    .zone_valid(zone_valid), .valid_stb(valid_stb)
  );

  // Busy shares the single output register stage with the waveforms.
  always_ff @(posedge clk) begin
    if (rst) busy <= 1'b0;
    else     busy <= (phase != PH_IDLE);
  end

  // One transfer gate drive per colour row, all pulsing together.
  for (genvar r = 0; r < N_ROWS; r++) begin : g_row
    assign tg_rows[r] = xfer;
  end
endmodule

// File: rtl/ccd_line_timer_chk.sv
module ccd_line_timer_chk #(
  parameter int unsigned N_ROWS = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              phi2,
  input logic              phi1_last,
  input logic              rs_pulse,
  input logic              clamp,
  input logic [N_ROWS-1:0] tg_rows,
  input logic              zone_dummy,
  input logic              zone_ob,
  input logic              zone_valid,
  input logic              valid_stb,
  input logic              mode_line
);
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!rs_pulse && !clamp && (tg_rows == '0)));

  a_r3_gate_in_line: assert property (@(posedge clk) disable iff (rst)
    (|tg_rows) |-> busy);

  a_r4_bit_hold_high: assert property (@(posedge clk) disable iff (rst)
    ((|tg_rows) && !mode_line) |-> (rs_pulse && clamp));

  a_r5_clamp_inverse: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_line) |-> (clamp == !(|tg_rows)));

  a_r5_no_reset_low_clamp: assert property (@(posedge clk) disable iff (rst)
    (busy && mode_line && !clamp) |-> !rs_pulse);

  a_r8_last_low_at_phi2: assert property (@(posedge clk) disable iff (rst)
    $rose(phi2) |-> !phi1_last);

  a_r10_zone_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({zone_dummy, zone_ob, zone_valid}));

  a_r10_zone_in_line: assert property (@(posedge clk) disable iff (rst)
    (zone_dummy || zone_ob || zone_valid) |-> busy);

  a_r11_strobe_valid: assert property (@(posedge clk) disable iff (rst)
    valid_stb |-> zone_valid);
endmodule

bind ccd_line_timer ccd_line_timer_chk #(.N_ROWS(N_ROWS)) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .phi2(phi2), .phi1_last(phi1_last),
  .rs_pulse(rs_pulse), .clamp(clamp), .tg_rows(tg_rows),
  .zone_dummy(zone_dummy), .zone_ob(zone_ob), .zone_valid(zone_valid),
  .valid_stb(valid_stb), .mode_line(mode_q)
);

// File: tb/ccd_line_timer_test.sv
module ccd_line_timer_test;
  import ccd_timer_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NF = 2, NO = 3, NG = 1, NV = 10, NT = 4;
  localparam int TOT = NF + NO + NG + NV + NT;
  localparam int PW = $clog2(TOT + 1);

  logic clk = 1'b0, rst = 1'b1, line_start = 1'b0, line_mode_sel = 1'b0;
  logic [TW-1:0] pix_period = 8, rst_width = 2, rst_clamp_gap = 1, clamp_width = 2;
  logic [TW-1:0] tg_setup = 4, tg_width = 6, tg_hold = 3;
  logic phi1, phi2, phi1_last, rs_pulse, clamp, busy;
  logic zone_dummy, zone_ob, zone_valid, valid_stb;
  logic [2:0] tg_rows;
  logic [PW-1:0] pix_index;

  ccd_line_timer #(.N_FRONT(NF), .N_OB(NO), .N_GAP(NG), .N_VALID(NV), .N_TAIL(NT)) uut (
    .clk(clk), .rst(rst), .line_start(line_start), .line_mode_sel(line_mode_sel),
    .pix_period(pix_period), .rst_width(rst_width), .rst_clamp_gap(rst_clamp_gap),
    .clamp_width(clamp_width), .tg_setup(tg_setup), .tg_width(tg_width), .tg_hold(tg_hold),
    .phi1(phi1), .phi2(phi2), .phi1_last(phi1_last), .rs_pulse(rs_pulse), .clamp(clamp),
    .tg_rows(tg_rows), .busy(busy), .pix_index(pix_index), .zone_dummy(zone_dummy),
    .zone_ob(zone_ob), .zone_valid(zone_valid), .valid_stb(valid_stb)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_errors = 0;
  bit done = 0;

  // Statistics of the last line
  int busy_cyc, tg_cyc, tg_rises, split, win, pre, post, stat, w_rs, w_clp, w_inv;
  int npix, idx_err, ph_err, rs_err, clp_err, rs_rises, clp_rises, zone_err, stb_err, stb_cnt, max_idx;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_line(input bit mode, input int p, input int rw, input int gp, input int cw,
                          input int su, input int tw, input int hd, input int flip_at);
    int cc, half, guard, pidx;
    bit ptg, prs, pclp, tgv, e_phi1, e_last, e_rs, e_clp, e_stb;
    logic [2:0] ez;
    line_mode_sel = mode; pix_period = p; rst_width = rw; rst_clamp_gap = gp;
    clamp_width = cw; tg_setup = su; tg_width = tw; tg_hold = hd;
    busy_cyc = 0; tg_cyc = 0; tg_rises = 0; split = 0; win = 0; pre = 0; post = 0; stat = 0;
    w_rs = 0; w_clp = 0; w_inv = 0; npix = 0; idx_err = 0; ph_err = 0; rs_err = 0; clp_err = 0;
    rs_rises = 0; clp_rises = 0; zone_err = 0; stb_err = 0; stb_cnt = 0; max_idx = 0;
    cc = 0; guard = 0; pidx = 0; ptg = 0; prs = 0; pclp = 0;
    half = p / 2;
    @(negedge clk); line_start = 1'b1;
    @(negedge clk); line_start = 1'b0;
    while (1) begin
      if (busy) begin
        busy_cyc++;
        tgv = |tg_rows;
        if (tg_rows != 3'b000 && tg_rows != 3'b111) split++;
        if (tgv && !ptg) tg_rises++;
        if (tgv) tg_cyc++;
        if (pix_index == 0) begin
          win++;
          if (!tgv && tg_rises == 0) pre++;
          if (!tgv && tg_rises > 0) post++;
          if (phi1 && !phi2 && phi1_last) stat++;
          if (rs_pulse) w_rs++;
          if (clamp) w_clp++;
          if (clamp == !tgv) w_inv++;
          if (zone_dummy || zone_ob || zone_valid || valid_stb) zone_err++;
        end else begin
          if (int'(pix_index) != pidx) begin
            cc = 0; npix++;
            if (int'(pix_index) != pidx + 1) idx_err++;
          end else cc++;
          e_phi1 = cc < half;
          e_last = cc < half - 1;
          e_rs = cc < rw;
          e_clp = mode ? 1'b1 : (cc >= rw + gp && cc < rw + gp + cw);
          if (phi1 != e_phi1 || phi2 != !e_phi1 || phi1_last != e_last) ph_err++;
          if (rs_pulse != e_rs) rs_err++;
          if (clamp != e_clp) clp_err++;
          if (rs_pulse && (!prs || cc == 0)) rs_rises++;
          if (clamp && !pclp) clp_rises++;
          if (pix_index <= NF) ez = 3'b100;
          else if (pix_index <= NF + NO) ez = 3'b010;
          else if (pix_index <= NF + NO + NG) ez = 3'b100;
          else if (pix_index <= NF + NO + NG + NV) ez = 3'b001;
          else ez = 3'b100;
          if ({zone_dummy, zone_ob, zone_valid} != ez) zone_err++;
          e_stb = (ez == 3'b001) && (cc == p - 1);
          if (valid_stb != e_stb) stb_err++;
          if (valid_stb) stb_cnt++;
          if (int'(pix_index) > max_idx) max_idx = int'(pix_index);
        end
        ptg = tgv; prs = rs_pulse; pclp = clamp; pidx = int'(pix_index);
        if (busy_cyc == flip_at) begin
          line_mode_sel = !mode; pix_period = 5; rst_width = 3; clamp_width = 1;
          line_start = 1'b1;
        end else if (busy_cyc == flip_at + 1) line_start = 1'b0;
      end else if (busy_cyc > 0) break;
      else if (guard++ > 5) break;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && tg_rows == 0 && !rs_pulse && !clamp, "R1 idle drive", {busy, rs_pulse, clamp}, 0);
    check(phi1 && !phi2 && phi1_last, "R1 clock park", {phi1, phi2, phi1_last}, 5);
    check(pix_index == 0 && !zone_dummy && !zone_ob && !zone_valid && !valid_stb,
          "R1 tags clear", int'(pix_index), 0);
  endtask

  task automatic common_burst(input int p);
    check(npix == TOT && max_idx == TOT && idx_err == 0, "R9 pixel count", npix, TOT);
    check(rs_rises == TOT, "R9 reset per pixel", rs_rises, TOT);
    check(ph_err == 0, "R8 shift phases", ph_err, 0);
    check(zone_err == 0, "R10 zone tags", zone_err, 0);
    check(stb_err == 0 && stb_cnt == NV, "R11 valid strobes", stb_cnt, NV);
    check(busy_cyc == tg_setup + tg_width + tg_hold + TOT * p, "R2 busy length",
          busy_cyc, tg_setup + tg_width + tg_hold + TOT * p);
  endtask

  task automatic t_bit_clamp;
    run_line(1'b0, 8, 2, 1, 2, 4, 6, 3, -1);
    check(tg_rises == 1 && tg_cyc == 6 && split == 0, "R3 gate width", tg_cyc, 6);
    check(pre == 4 && post == 3 && stat == win, "R3 setup hold static", pre * 10 + post, 43);
    check(w_rs == win && w_clp == win, "R4 reset clamp held", w_rs + w_clp, 2 * win);
    check(rs_err == 0 && clp_err == 0, "R6 bit clamp pulses", rs_err + clp_err, 0);
    common_burst(8);
  endtask

  task automatic t_line_clamp;
    run_line(1'b1, 6, 1, 2, 2, 3, 5, 2, -1);
    check(tg_rises == 1 && tg_cyc == 5, "R3 gate width line mode", tg_cyc, 5);
    check(w_inv == win && w_rs == 0, "R5 clamp inverse no reset", w_rs, 0);
    check(clp_rises == 0 && clp_err == 0 && rs_err == 0, "R7 line clamp burst", clp_rises, 0);
    common_burst(6);
    check(busy_cyc == 130, "R13 period 6 line", busy_cyc, 130);
  endtask

  task automatic t_odd_period;
    run_line(1'b0, 7, 1, 0, 3, 2, 3, 1, -1);
    check(rs_err == 0 && clp_err == 0, "R6 zero gap clamp", rs_err + clp_err, 0);
    check(ph_err == 0, "R13 odd period phases", ph_err, 0);
    common_burst(7);
  endtask

  task automatic t_midline_change;
    int extra;
    run_line(1'b0, 8, 2, 1, 2, 4, 6, 3, 30);
    check(rs_err == 0 && clp_err == 0 && ph_err == 0, "R12 captured config", rs_err + clp_err + ph_err, 0);
    check(busy_cyc == 173, "R12 captured period", busy_cyc, 173);
    extra = 0;
    repeat (20) begin @(negedge clk); if (busy) extra++; end
    check(extra == 0, "R2 start while busy ignored", extra, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_bit_clamp();
    t_line_clamp();
    t_odd_period();
    t_midline_change();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule